// File: doc/BRIEF.md
# Multi-Core Private Region Decoder

This block sits in front of a 4 KB private peripheral window that up to four CPU cores share. Every access carries the ID of the core that issued it. The decoder looks at the low 12 bits of the address and sends the access to one of three places. The first is a small local block of snoop-control registers. The second is a per-core port of the interrupt CPU interface. The third is a per-core port of the timer/watchdog pair. The interrupt controller and the timers live elsewhere. This block reaches them over simple request/response ports, and those ports answer read data in the same cycle as the request.

Each downstream resource can be reached in two ways. An alias window always resolves to the requesting core's own resource. A set of banked windows, one per core, names a core explicitly through the address. Inside a timer window, one address bit chooses between the timer and the watchdog of the selected core. A core index at or above the configured core count is treated as absent. An access to an absent core is dropped quietly: nothing is forwarded, a read returns zero, and no error is raised. An undefined access to the snoop-control range pulses a decode-error output. The request path is purely combinational. Read data comes back one cycle later from a single register stage.

Top module: `priv_window_decoder`

## Requirements
- R1: Only address bits [11:0] (the offset) take part in decoding. Offsets 0x000-0x0FF are snoop-control, 0x100-0x5FF are interrupt interface, and 0x600-0xAFF are timer; the upper address bits have no effect.
- R2: The snoop-control register at offset 0x00 stores only bit 0 of the write data. That bit drives `snoop_en` from the clock edge after the write and reads back as bit 0, with all other bits zero. It resets to 0.
- R3: Offset 0x04 reads as (((1<<N)-1)<<4) | (N-1), where N is `NUM_CORES`. Offsets 0x08 and 0x0C read as zero. A write to 0x0C is accepted, raises no error and changes nothing.
- R4: Any other snoop-control access pulses `dec_err` in the same cycle. This covers reads of offsets other than 0x00, 0x04, 0x08 and 0x0C, and writes to offsets other than 0x00 and 0x0C. Such an access forwards nothing, changes no state, and a read returns zero.
- R5: Offsets 0x100-0x1FF forward to the interrupt port of the requesting core (`req_core`), with `irq_req_off` = offset[7:0].
- R6: Offsets 0x200-0x5FF forward to the interrupt port of core (offset-0x200)>>8, with `irq_req_off` = offset[7:0].
- R7: Offsets 0x600-0x6FF select the requesting core's timer pair. Offsets 0x700-0xAFF select core (offset-0x700)>>8.
- R8: The timer unit index is core*2 + offset bit 5, so bit 5 = 1 selects the watchdog. `tmr_req_off` = offset[3:0].
- R9: When the resolved core index (from an alias or a banked window) is at or above N, nothing is forwarded, a read returns zero, and `dec_err` stays low.
- R10: Every read request produces `rsp_valid` exactly one cycle later, with `rsp_rdata` holding its data. A write or an idle cycle produces no response and leaves `rsp_rdata` unchanged.
- R11: Offsets 0xB00-0xFFF forward nothing and raise no error. A read there returns zero.
- R12: At most one of `irq_req_valid`, `tmr_req_valid` and `dec_err` is high in a cycle, and only while `req_valid` is high. A forwarded request carries `req_write` and `req_wdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | 2 | ID of the requesting core |
| req_addr | input | ADDR_W | Access address; only bits [11:0] are decoded |
| req_wdata | input | 32 | Write data |
| dec_err | output | 1 | Decode-error pulse for an undefined snoop-control access |
| rsp_valid | output | 1 | Read response valid, one cycle after a read |
| rsp_rdata | output | 32 | Registered read data |
| snoop_en | output | 1 | Stored snoop-control enable bit |
| irq_req_valid | output | 1 | Request to an interrupt interface port |
| irq_req_write | output | 1 | Write flag to the interrupt port |
| irq_req_core | output | 2 | Selected core for the interrupt port |
| irq_req_off | output | 8 | Register offset inside the interrupt interface |
| irq_req_wdata | output | 32 | Write data to the interrupt port |
| irq_rsp_rdata | input | 32 | Same-cycle read data from the interrupt port |
| tmr_req_valid | output | 1 | Request to a timer/watchdog unit |
| tmr_req_write | output | 1 | Write flag to the timer port |
| tmr_req_unit | output | 3 | Unit index, core*2 + watchdog select |
| tmr_req_off | output | 4 | Register offset inside the unit |
| tmr_req_wdata | output | 32 | Write data to the timer port |
| tmr_rsp_rdata | input | 32 | Same-cycle read data from the timer port |

## Verification
The bench builds the block with three cores present, so core index 3 is absent. It drives alias and banked accesses from different requesting cores, and this shows whether the core index comes from `req_core` or from the address window. Timer offsets with bit 5 clear and set, plus low nibbles other than zero, show whether the watchdog bit and the forwarded offset land in the right fields. Banked and alias accesses that resolve to core 3, together with offsets in the unmapped top range, separate the silent-drop path from the decode-error path. Back-to-back reads to different targets, and snoop-control writes with junk in the upper data bits or the upper address bits, confirm the response timing and that only bit 0 is stored.

// File: rtl/priv_dec_pkg.sv
package priv_dec_pkg;

    // Fixed geometry of the private window
    localparam int OFF_W      = 12;              // decoded offset width
    localparam int WIN_W      = 4;               // 256-byte window index width
    localparam int MAX_CORES  = 4;
    localparam int CORE_W     = $clog2(MAX_CORES);
    localparam int UNIT_W     = CORE_W + 1;      // core + timer/watchdog select
    localparam int DATA_W     = 32;
    localparam int IRQ_OFF_W  = 8;
    localparam int TMR_OFF_W  = 4;
    localparam int TMR_SEL_BIT = 5;

    // Window boundaries in units of 256 bytes
    localparam logic [WIN_W-1:0] WIN_SNOOP     = 4'd0;
    localparam logic [WIN_W-1:0] WIN_IRQ_ALIAS = 4'd1;
    localparam logic [WIN_W-1:0] WIN_IRQ_BANK  = 4'd2;
    localparam logic [WIN_W-1:0] WIN_TMR_ALIAS = WIN_IRQ_BANK + WIN_W'(MAX_CORES);
    localparam logic [WIN_W-1:0] WIN_TMR_BANK  = WIN_TMR_ALIAS + 4'd1;
    localparam logic [WIN_W-1:0] WIN_END       = WIN_TMR_BANK + WIN_W'(MAX_CORES);

    // Snoop-control register offsets
    localparam logic [7:0] SNP_CTRL = 8'h00;
    localparam logic [7:0] SNP_CFG  = 8'h04;
    localparam logic [7:0] SNP_STAT = 8'h08;
    localparam logic [7:0] SNP_INV  = 8'h0C;

    typedef enum logic [1:0] {
        RGN_SNOOP = 2'd0,
        RGN_IRQ   = 2'd1,
        RGN_TMR   = 2'd2,
        RGN_NONE  = 2'd3
    } rgn_e;

    typedef struct packed {
        rgn_e              rgn;
        logic              present;
        logic [CORE_W-1:0] core;
    } dec_t;

    // Configuration word: one presence bit per core from bit 4, count-1 low
    function automatic logic [DATA_W-1:0] cfg_word(input int n);
        logic [DATA_W-1:0] mask;
        mask = (DATA_W'(1) << n) - DATA_W'(1);
        return (mask << 4) | DATA_W'(n - 1);
    endfunction

endpackage

// File: rtl/region_decode.sv
module region_decode
    import priv_dec_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [WIN_W-1:0]  win,
    input  logic [CORE_W-1:0] req_core,
    output dec_t              dec
);
    localparam logic [WIN_W-1:0] NC = WIN_W'(NUM_CORES);

    logic [WIN_W-1:0] idx;
    rgn_e             rgn;

    always_comb begin
        idx = '0;
        rgn = RGN_NONE;
        if (win == WIN_SNOOP) begin
            rgn = RGN_SNOOP;
        end else if (win == WIN_IRQ_ALIAS) begin
            rgn = RGN_IRQ;
            idx = {{(WIN_W-CORE_W){1'b0}}, req_core};
        end else if (win < WIN_TMR_ALIAS) begin
            rgn = RGN_IRQ;
            idx = win - WIN_IRQ_BANK;
        end else if (win == WIN_TMR_ALIAS) begin
            rgn = RGN_TMR;
            idx = {{(WIN_W-CORE_W){1'b0}}, req_core};
        end else if (win < WIN_END) begin
            rgn = RGN_TMR;
            idx = win - WIN_TMR_BANK;
        end
    end

    always_comb begin
        dec.rgn     = rgn;
        dec.present = (idx < NC);
        dec.core    = idx[CORE_W-1:0];
    end

endmodule

// File: rtl/snoop_regs.sv
module snoop_regs
    import priv_dec_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              wr,
    input  logic [7:0]        off,
    input  logic              wbit,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic              en
);
    localparam logic [DATA_W-1:0] CFG_VAL = cfg_word(NUM_CORES);

    logic legal;

    always_comb begin
        legal = 1'b0;
        rdata = '0;
        case (off)
            SNP_CTRL: begin
                legal = 1'b1;
                rdata = DATA_W'(en);
            end
            SNP_CFG: begin
                legal = !wr;
                rdata = CFG_VAL;
            end
            SNP_STAT: legal = !wr;
            SNP_INV:  legal = 1'b1;
            default:  legal = 1'b0;
        endcase
        if (!legal) rdata = '0;
        err = acc && !legal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= 1'b0;
        end else if (acc && wr && off == SNP_CTRL) begin
            en <= wbit;
        end
    end

endmodule

// File: rtl/rdata_ret.sv
module rdata_ret
    import priv_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_fire,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_fire;
            if (rd_fire) rsp_rdata <= rd_data;
        end
    end

endmodule

// File: rtl/priv_window_decoder.sv
module priv_window_decoder
    import priv_dec_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [CORE_W-1:0]    req_core,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 dec_err,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 snoop_en,
    output logic                 irq_req_valid,
    output logic                 irq_req_write,
    output logic [CORE_W-1:0]    irq_req_core,
    output logic [IRQ_OFF_W-1:0] irq_req_off,
    output logic [DATA_W-1:0]    irq_req_wdata,
    input  logic [DATA_W-1:0]    irq_rsp_rdata,
    output logic                 tmr_req_valid,
    output logic                 tmr_req_write,
    output logic [UNIT_W-1:0]    tmr_req_unit,
    output logic [TMR_OFF_W-1:0] tmr_req_off,
    output logic [DATA_W-1:0]    tmr_req_wdata,
    input  logic [DATA_W-1:0]    tmr_rsp_rdata
);
    logic [OFF_W-1:0]  offset;
    logic              addr_unused;
    dec_t              dec;
    logic              snp_acc;
    logic [DATA_W-1:0] snp_rdata;
    logic [DATA_W-1:0] rd_mux;

    assign offset      = req_addr[OFF_W-1:0];
    assign addr_unused = ^req_addr[ADDR_W-1:OFF_W];

    region_decode #(.NUM_CORES(NUM_CORES)) u_region (
        .win      (offset[OFF_W-1:OFF_W-WIN_W]),
        .req_core (req_core),
        .dec      (dec)
    );

    assign snp_acc = req_valid && (dec.rgn == RGN_SNOOP);

    snoop_regs #(.NUM_CORES(NUM_CORES)) u_snoop (
        .clk   (clk),
        .rst   (rst),
        .acc   (snp_acc),
        .wr    (req_write),
        .off   (offset[7:0]),
        .wbit  (req_wdata[0]),
        .rdata (snp_rdata),
        .err   (dec_err),
        .en    (snoop_en)
    );

    // Downstream request ports
    assign irq_req_valid = req_valid && (dec.rgn == RGN_IRQ) && dec.present;
    assign irq_req_write = req_write;
    assign irq_req_core  = dec.core;
    assign irq_req_off   = offset[IRQ_OFF_W-1:0];
    assign irq_req_wdata = req_wdata;

    assign tmr_req_valid = req_valid && (dec.rgn == RGN_TMR) && dec.present;
    assign tmr_req_write = req_write;
    assign tmr_req_unit  = {dec.core, offset[TMR_SEL_BIT]};
    assign tmr_req_off   = offset[TMR_OFF_W-1:0];
    assign tmr_req_wdata = req_wdata;

    // Read data selection ahead of the return register
    always_comb begin
        rd_mux = '0;
        case (dec.rgn)
            RGN_SNOOP: rd_mux = snp_rdata;
            RGN_IRQ:   if (dec.present) rd_mux = irq_rsp_rdata;
            RGN_TMR:   if (dec.present) rd_mux = tmr_rsp_rdata;
            default:   rd_mux = '0;
        endcase
    end

    rdata_ret u_ret (
        .clk       (clk),
        .rst       (rst),
        .rd_fire   (req_valid && !req_write),
        .rd_data   (rd_mux),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/priv_window_decoder_chk.sv
module priv_window_decoder_chk
    import priv_dec_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [WIN_W-1:0]  win,
    input logic              dec_err,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              snoop_en,
    input logic              irq_req_valid,
    input logic [CORE_W-1:0] irq_req_core,
    input logic              tmr_req_valid,
    input logic [UNIT_W-1:0] tmr_req_unit
);
    localparam logic [CORE_W:0] NC = (CORE_W+1)'(NUM_CORES);

    p_one_target_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_req_valid, tmr_req_valid, dec_err}));

    p_needs_req_r12: assert property (@(posedge clk) disable iff (rst)
        (irq_req_valid || tmr_req_valid || dec_err) |-> req_valid);

    p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    p_no_rsp_r10: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> (!rsp_valid && $stable(rsp_rdata)));

    p_err_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && dec_err) |=> (rsp_rdata == '0));

    p_err_only_snoop_r4: assert property (@(posedge clk) disable iff (rst)
        dec_err |-> (win == WIN_SNOOP));

    p_irq_present_r9: assert property (@(posedge clk) disable iff (rst)
        irq_req_valid |-> ({1'b0, irq_req_core} < NC));

    p_tmr_present_r9: assert property (@(posedge clk) disable iff (rst)
        tmr_req_valid |-> ({1'b0, tmr_req_unit[UNIT_W-1:1]} < NC));

    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && win >= WIN_END) |-> (!irq_req_valid && !tmr_req_valid && !dec_err));

    p_en_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> $stable(snoop_en));

endmodule

bind priv_window_decoder priv_window_decoder_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .win           (req_addr[11:8]),
    .dec_err       (dec_err),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .snoop_en      (snoop_en),
    .irq_req_valid (irq_req_valid),
    .irq_req_core  (irq_req_core),
    .tmr_req_valid (tmr_req_valid),
    .tmr_req_unit  (tmr_req_unit)
);

// File: tb/priv_window_decoder_tb.sv
module priv_window_decoder_tb;

    localparam int NCORES = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_core = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        dec_err, rsp_valid, snoop_en;
    logic [31:0] rsp_rdata;
    logic        irq_req_valid, irq_req_write;
    logic [1:0]  irq_req_core;
    logic [7:0]  irq_req_off;
    logic [31:0] irq_req_wdata, irq_rsp_rdata;
    logic        tmr_req_valid, tmr_req_write;
    logic [2:0]  tmr_req_unit;
    logic [3:0]  tmr_req_off;
    logic [31:0] tmr_req_wdata, tmr_rsp_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // Downstream models: same-cycle data tagged with target and offset
    assign irq_rsp_rdata = 32'hA000_0000 | (32'(irq_req_core) << 8) | 32'(irq_req_off);
    assign tmr_rsp_rdata = 32'hB000_0000 | (32'(tmr_req_unit) << 8) | 32'(tmr_req_off);

    priv_window_decoder #(.NUM_CORES(NCORES), .ADDR_W(32)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_core(req_core),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .dec_err(dec_err), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .snoop_en(snoop_en),
        .irq_req_valid(irq_req_valid), .irq_req_write(irq_req_write),
        .irq_req_core(irq_req_core), .irq_req_off(irq_req_off),
        .irq_req_wdata(irq_req_wdata), .irq_rsp_rdata(irq_rsp_rdata),
        .tmr_req_valid(tmr_req_valid), .tmr_req_write(tmr_req_write),
        .tmr_req_unit(tmr_req_unit), .tmr_req_off(tmr_req_off),
        .tmr_req_wdata(tmr_req_wdata), .tmr_rsp_rdata(tmr_rsp_rdata)
    );

    // kind: 0 local/dropped, 1 interrupt port, 2 timer port, 3 decode error
    typedef struct packed {
        logic        wr;
        logic [1:0]  core;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  kind;
        logic [2:0]  idx;
        logic [7:0]  off;
        logic [31:0] sdata;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd1, 32'h0000_0100, 32'h0,         2'd1, 3'd1, 8'h00, 32'h0},  // R5 alias
        '{1'b0, 2'd2, 32'hFFFF_F1F4, 32'h0,         2'd1, 3'd2, 8'hF4, 32'h0},  // R1 R5 high bits
        '{1'b0, 2'd0, 32'h0000_0200, 32'h0,         2'd1, 3'd0, 8'h00, 32'h0},  // R6 bank 0
        '{1'b0, 2'd0, 32'h0000_04A8, 32'h0,         2'd1, 3'd2, 8'hA8, 32'h0},  // R6 bank 2
        '{1'b0, 2'd1, 32'h0000_0510, 32'h0,         2'd0, 3'd0, 8'h00, 32'h0},  // R9 bank 3 absent
        '{1'b0, 2'd2, 32'h0000_0604, 32'h0,         2'd2, 3'd4, 8'h04, 32'h0},  // R7 alias timer
        '{1'b0, 2'd1, 32'h0000_0628, 32'h0,         2'd2, 3'd3, 8'h08, 32'h0},  // R8 alias watchdog
        '{1'b0, 2'd0, 32'h0000_080C, 32'h0,         2'd2, 3'd2, 8'h0C, 32'h0},  // R7 bank 1
        '{1'b0, 2'd0, 32'h0000_093C, 32'h0,         2'd2, 3'd5, 8'h0C, 32'h0},  // R8 bank 2 watchdog
        '{1'b1, 2'd0, 32'h0000_0A00, 32'h1234_5678, 2'd0, 3'd0, 8'h00, 32'h0},  // R9 write absent
        '{1'b0, 2'd3, 32'h0000_0100, 32'h0,         2'd0, 3'd0, 8'h00, 32'h0},  // R9 absent requester
        '{1'b0, 2'd3, 32'h0000_06F0, 32'h0,         2'd0, 3'd0, 8'h00, 32'h0},  // R9 absent requester timer
        '{1'b0, 2'd1, 32'h0000_0B40, 32'h0,         2'd0, 3'd0, 8'h00, 32'h0},  // R11 unmapped read
        '{1'b1, 2'd2, 32'h0000_0FFC, 32'hFFFF_FFFF, 2'd0, 3'd0, 8'h00, 32'h0},  // R11 unmapped write
        '{1'b0, 2'd0, 32'h0000_0004, 32'h0,         2'd0, 3'd0, 8'h00, 32'h72}, // R3 config
        '{1'b0, 2'd1, 32'h0000_0008, 32'h0,         2'd0, 3'd0, 8'h00, 32'h0},  // R3 status zero
        '{1'b0, 2'd0, 32'h0000_0010, 32'h0,         2'd3, 3'd0, 8'h00, 32'h0},  // R4 bad read
        '{1'b1, 2'd0, 32'h0000_0004, 32'h5,         2'd3, 3'd0, 8'h00, 32'h0},  // R4 bad write
        '{1'b1, 2'd1, 32'h0000_0700, 32'hCAFE_0001, 2'd2, 3'd0, 8'h00, 32'h0},  // R7 R12 write
        '{1'b1, 2'd0, 32'h0000_02FC, 32'h5555_AAAA, 2'd1, 3'd0, 8'hFC, 32'h0},  // R6 R12 write
        '{1'b0, 2'd2, 32'h0000_0001, 32'h0,         2'd3, 3'd0, 8'h00, 32'h0}   // R4 misaligned
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [1:0] core,
                         input logic [31:0] addr, input logic [31:0] wdata);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_core  = core;
        req_addr  = addr;
        req_wdata = wdata;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        #1;
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_rd;
        logic [2:0]  exp_hot;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // Reset state (R2, R10)
        chk("R2 reset snoop_en", 64'(snoop_en), 64'd0);
        chk("R10 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R10 reset rsp_rdata", 64'(rsp_rdata), 64'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].wr, VECS[i].core, VECS[i].addr, VECS[i].wdata);
            case (VECS[i].kind)
                2'd1:    exp_hot = 3'b100;
                2'd2:    exp_hot = 3'b010;
                2'd3:    exp_hot = 3'b001;
                default: exp_hot = 3'b000;
            endcase
            chk($sformatf("R12 route vec%0d", i),
                64'({irq_req_valid, tmr_req_valid, dec_err}), 64'(exp_hot));
            if (VECS[i].kind == 2'd1) begin
                chk($sformatf("R6 irq target vec%0d", i),
                    64'({irq_req_core, irq_req_off, irq_req_write}),
                    64'({VECS[i].idx[1:0], VECS[i].off, VECS[i].wr}));
                if (VECS[i].wr)
                    chk($sformatf("R12 irq wdata vec%0d", i), 64'(irq_req_wdata), 64'(VECS[i].wdata));
            end
            if (VECS[i].kind == 2'd2) begin
                chk($sformatf("R8 tmr target vec%0d", i),
                    64'({tmr_req_unit, tmr_req_off, tmr_req_write}),
                    64'({VECS[i].idx, VECS[i].off[3:0], VECS[i].wr}));
                if (VECS[i].wr)
                    chk($sformatf("R12 tmr wdata vec%0d", i), 64'(tmr_req_wdata), 64'(VECS[i].wdata));
            end
            case (VECS[i].kind)
                2'd1:    exp_rd = 32'hA000_0000 | (32'(VECS[i].idx) << 8) | 32'(VECS[i].off);
                2'd2:    exp_rd = 32'hB000_0000 | (32'(VECS[i].idx) << 8) | 32'(VECS[i].off[3:0]);
                2'd3:    exp_rd = 32'h0;
                default: exp_rd = VECS[i].sdata;
            endcase
            edge_wait();
            chk($sformatf("R10 rsp_valid vec%0d", i), 64'(rsp_valid), 64'(!VECS[i].wr));
            if (!VECS[i].wr)
                chk($sformatf("R10 rsp_rdata vec%0d", i), 64'(rsp_rdata), 64'(exp_rd));
        end
        idle();

        // R2: only bit 0 stored
        drive(1'b1, 2'd0, 32'h0000_0000, 32'hFFFF_FFFE);
        edge_wait();
        chk("R2 bit0 clear stored", 64'(snoop_en), 64'd0);
        drive(1'b1, 2'd1, 32'h1234_5000, 32'h0000_0003);
        edge_wait();
        chk("R1 R2 bit0 set via high addr", 64'(snoop_en), 64'd1);
        drive(1'b0, 2'd2, 32'h0000_0000, 32'h0);
        edge_wait();
        chk("R2 ctrl readback", 64'(rsp_rdata), 64'd1);

        // R3: invalidate write accepted, no effect
        drive(1'b1, 2'd0, 32'h0000_000C, 32'h0);
        chk("R3 inval no error", 64'(dec_err), 64'd0);
        edge_wait();
        chk("R3 inval keeps snoop_en", 64'(snoop_en), 64'd1);
        drive(1'b0, 2'd0, 32'h0000_000C, 32'h0);
        edge_wait();
        chk("R3 inval reads zero", 64'(rsp_rdata), 64'd0);

        // R4: illegal write leaves state, illegal read returns zero after nonzero
        drive(1'b1, 2'd0, 32'h0000_0008, 32'h0);
        chk("R4 status write errors", 64'(dec_err), 64'd1);
        edge_wait();
        chk("R4 error keeps snoop_en", 64'(snoop_en), 64'd1);
        drive(1'b0, 2'd0, 32'h0000_0004, 32'h0);
        edge_wait();
        chk("R3 config before error", 64'(rsp_rdata), 64'h72);
        drive(1'b0, 2'd0, 32'h0000_00FC, 32'h0);
        chk("R4 read 0xFC errors", 64'(dec_err), 64'd1);
        edge_wait();
        chk("R4 error read zero", 64'(rsp_rdata), 64'd0);

        // R10: back-to-back reads, then idle holds data
        drive(1'b0, 2'd0, 32'h0000_0300, 32'h0);
        edge_wait();
        chk("R10 b2b first", 64'({rsp_valid, rsp_rdata}), 64'({1'b1, 32'hA000_0100}));
        drive(1'b0, 2'd0, 32'h0000_0620, 32'h0);
        edge_wait();
        chk("R10 b2b second", 64'({rsp_valid, rsp_rdata}), 64'({1'b1, 32'hB000_0100}));
        idle();
        edge_wait();
        chk("R10 idle no rsp", 64'({rsp_valid, rsp_rdata}), 64'({1'b0, 32'hB000_0100}));

        // Reset mid-run clears the stored bit
        @(negedge clk);
        rst = 1'b1;
        edge_wait();
        chk("R2 reset clears snoop_en", 64'(snoop_en), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule